// File: doc/BRIEF.md
# Transmit Interrupt Moderation Timer

This block sits beside the transmit path of a 10/100 Ethernet MAC. It decides when the MAC raises two interrupts. The first is a transmit-complete interrupt, which is held back until a programmed number of consecutive successful transmit bursts have finished. The second is a transmit-deferred interrupt, which comes from an idle countdown. The countdown starts over at every transmit completion and fires if no new transmit begins before it runs out.

Software programs both limits through a single 32-bit write port. The countdown is measured in steps. A step is a fixed number of reference ticks, and that number depends on the line speed: the 10 Mb/s step is ten times longer than the 100 Mb/s step when the default parameters are used. The countdown only advances while the deferred-interrupt enable input is high. Both interrupt outputs are one-cycle pulses, meant for an interrupt status register that lives outside this block.

Top module: `tx_irq_moderator`

## Requirements
- R1: After a synchronous active-low reset, both interrupt outputs are low, the success count is zero, both programmed fields are zero and the countdown is idle.
- R2: A write stores the burst limit from data bits 20:16 and the timeout from bits 11:0. All other bits are ignored.
- R3: When a successful completion (tx_done with tx_ok high) brings the success count up to the burst limit, irq_done pulses high in the next cycle.
- R4: A burst limit of zero behaves as a limit of one, so every successful completion raises irq_done.
- R5: A failed completion (tx_done with tx_ok low) clears the success count and never raises irq_done.
- R6: When irq_done fires, the success count returns to zero, so the full limit must be reached again before the next interrupt.
- R7: Every completion, successful or failed, reloads the countdown from the timeout field and restarts the step prescaler. If the countdown reaches zero, irq_defer pulses high in the cycle after the final step.
- R8: A countdown step is STEP_FAST reference ticks long when speed_100 is 1, and STEP_SLOW reference ticks long when speed_100 is 0.
- R9: While defer_en is low, the countdown and its prescaler hold their values. No irq_defer is raised, and counting resumes where it stopped when defer_en returns high.
- R10: A tx_start pulse cancels a pending countdown, and no irq_defer follows. If tx_start and tx_done arrive in the same cycle, the cancel wins.
- R11: A completion with a timeout field of zero does not arm the countdown.
- R12: Each interrupt is a single-cycle pulse for each event that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the moderation register |
| cfg_wdata | input | 32 | Write data (burst limit 20:16, timeout 11:0) |
| defer_en | input | 1 | Enables the deferred-interrupt countdown |
| speed_100 | input | 1 | 1 selects 100 Mb/s step length, 0 selects 10 Mb/s |
| ref_tick | input | 1 | Reference tick that feeds the step prescaler |
| tx_start | input | 1 | Pulse: a packet transmit begins |
| tx_done | input | 1 | Pulse: a transmit burst finished |
| tx_ok | input | 1 | Qualifies tx_done as successful |
| irq_done | output | 1 | Transmit-complete interrupt pulse |
| irq_defer | output | 1 | Transmit-deferred interrupt pulse |

## Verification
A wrong success count shows up as irq_done arriving on the wrong completion. This becomes visible within one burst limit of completions after a reset, a failure or a previous interrupt. A fault in the countdown, the prescaler or the freeze logic moves the irq_defer pulse to a different cycle, or makes it appear or vanish. Comparing the pulse against an exact expected cycle number exposes such faults within timeout × step cycles of the last completion. Cancel and zero-timeout faults show up as a stray irq_defer within the same window.

// File: rtl/txim_pkg.sv
// Shared layout and types for the transmit interrupt moderator.
// Assumes a 32-bit register write port.
package txim_pkg;
    localparam int REG_W     = 32;
    localparam int BURST_W   = 5;
    localparam int BURST_LSB = 16;
    localparam int TMO_W     = 12;
    localparam int TMO_LSB   = 0;

    typedef struct packed {
        logic [BURST_W-1:0] burst;
        logic [TMO_W-1:0]   tmo;
    } txim_cfg_t;
endpackage

// File: rtl/txim_cfg_reg.sv
// Moderation register: captures the burst limit and the timeout on a write
// and ignores the reserved bits. Assumes the writes are single-cycle strobes.
module txim_cfg_reg
    import txim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output txim_cfg_t        cfg
);
    // Store the two fields on a write; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            cfg.burst <= wdata[BURST_LSB +: BURST_W];
            cfg.tmo   <= wdata[TMO_LSB +: TMO_W];
        end
    end
endmodule

// File: rtl/txim_burst_ctr.sv
// Counts consecutive successful completions and pulses when the limit is
// reached. A limit of zero is taken as one. Assumes tx_ok is valid with done.
module txim_burst_ctr
    import txim_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done,
    input  logic               ok,
    input  logic [BURST_W-1:0] limit,
    output logic               irq
);
    logic [BURST_W-1:0] cnt;
    logic [BURST_W:0]   next_cnt;
    logic [BURST_W:0]   eff_limit;

    // Effective limit and the incremented count, one bit wider to avoid wrap.
    always_comb begin
        eff_limit = (limit == '0) ? (BURST_W+1)'(1) : {1'b0, limit};
        next_cnt  = {1'b0, cnt} + (BURST_W+1)'(1);
    end

    // Advance, clear or fire on each completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (done) begin
                if (!ok) begin
                    cnt <= '0;
                end else if (next_cnt >= eff_limit) begin
                    cnt <= '0;
                    irq <= 1'b1;
                end else begin
                    cnt <= next_cnt[BURST_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/txim_step_prescaler.sv
// Divides reference ticks into countdown steps whose length depends on the
// line speed. Assumes STEP_FAST and STEP_SLOW are at least 1.
module txim_step_prescaler #(
    parameter int STEP_FAST = 4,
    parameter int STEP_SLOW = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic ref_tick,
    input  logic speed_100,
    output logic step
);
    localparam int STEP_MAX = (STEP_SLOW > STEP_FAST) ? STEP_SLOW : STEP_FAST;
    localparam int PW       = (STEP_MAX > 1) ? $clog2(STEP_MAX) : 1;

    logic [PW-1:0] pre;
    logic [PW-1:0] lim;

    // Pick the terminal count for the current speed and flag the step.
    always_comb begin
        lim  = speed_100 ? PW'(STEP_FAST - 1) : PW'(STEP_SLOW - 1);
        step = run && ref_tick && (pre >= lim);
    end

    // Count reference ticks while running; restart on clear or at a step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pre <= '0;
        end else if (run && ref_tick) begin
            pre <= (pre >= lim) ? '0 : pre + PW'(1);
        end
    end
endmodule

// File: rtl/txim_defer_timer.sv
// Idle countdown for the deferred interrupt. It is reloaded by a completion
// and cancelled by a transmit start, and it pulses when it reaches zero.
// Assumes step is only high while the timer runs.
module txim_defer_timer
    import txim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             cancel,
    input  logic [TMO_W-1:0] tmo,
    input  logic             step,
    output logic             armed,
    output logic             irq
);
    logic [TMO_W-1:0] cnt;

    // Cancel beats reload; each step decrements, and the last step fires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (cancel) begin
                armed <= 1'b0;
            end else if (load) begin
                cnt   <= tmo;
                armed <= (tmo != '0);
            end else if (armed && step) begin
                if (cnt == TMO_W'(1)) begin
                    cnt   <= '0;
                    armed <= 1'b0;
                    irq   <= 1'b1;
                end else begin
                    cnt <= cnt - TMO_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/tx_irq_moderator.sv
// Top of the transmit interrupt moderator. Combines the register, the burst
// counter, the step prescaler and the idle countdown. Assumes all inputs are
// synchronous to clk and that tx_start, tx_done and ref_tick are pulses.
module tx_irq_moderator
    import txim_pkg::*;
#(
    parameter int STEP_FAST = 4,
    parameter int STEP_SLOW = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             defer_en,
    input  logic             speed_100,
    input  logic             ref_tick,
    input  logic             tx_start,
    input  logic             tx_done,
    input  logic             tx_ok,
    output logic             irq_done,
    output logic             irq_defer
);
    txim_cfg_t cfg;
    logic      timer_armed;
    logic      step;
    logic      pre_run;
    logic      pre_clear;

    // Prescaler runs only while the countdown is armed and enabled.
    always_comb begin
        pre_run   = timer_armed && defer_en;
        pre_clear = tx_done || tx_start;
    end

    txim_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    txim_burst_ctr u_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (tx_done),
        .ok    (tx_ok),
        .limit (cfg.burst),
        .irq   (irq_done)
    );

    txim_step_prescaler #(
        .STEP_FAST (STEP_FAST),
        .STEP_SLOW (STEP_SLOW)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (pre_clear),
        .run       (pre_run),
        .ref_tick  (ref_tick),
        .speed_100 (speed_100),
        .step      (step)
    );

    txim_defer_timer u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tx_done),
        .cancel (tx_start),
        .tmo    (cfg.tmo),
        .step   (step),
        .armed  (timer_armed),
        .irq    (irq_defer)
    );
endmodule

// File: rtl/txim_checker.sv
// Port-level properties of the transmit interrupt moderator, bound to the top.
module txim_checker (
    input logic clk,
    input logic rst_n,
    input logic defer_en,
    input logic tx_start,
    input logic tx_done,
    input logic tx_ok,
    input logic irq_done,
    input logic irq_defer
);
    // R1: the cycle after a reset edge, both interrupts are low
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq_done && !irq_defer));

    // R3: irq_done only follows a successful completion
    a_r3_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> $past(tx_done && tx_ok));

    // R5: a failed completion never raises irq_done
    a_r5_fail_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !tx_ok) |=> !irq_done);

    // R9: no deferred interrupt follows a cycle with the countdown disabled
    a_r9_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !defer_en |=> !irq_defer);

    // R10: a transmit start suppresses the deferred interrupt
    a_r10_start_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !irq_defer);
endmodule

bind tx_irq_moderator txim_checker u_txim_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .defer_en  (defer_en),
    .tx_start  (tx_start),
    .tx_done   (tx_done),
    .tx_ok     (tx_ok),
    .irq_done  (irq_done),
    .irq_defer (irq_defer)
);

// File: tb/tx_irq_moderator_tb_top.sv
// Scoreboard bench: driver tasks queue the expected pulse cycles, and a
// monitor pops and compares them as the pulses appear.
module tx_irq_moderator_tb_top;
    localparam int SF = 4;
    localparam int SS = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        defer_en = 1'b0;
    logic        speed_100 = 1'b1;
    logic        ref_tick = 1'b1;
    logic        tx_start = 1'b0;
    logic        tx_done = 1'b0;
    logic        tx_ok = 1'b0;
    logic        irq_done;
    logic        irq_defer;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int exp_done_q[$];
    int exp_defer_q[$];
    int m_cnt = 0;
    int m_burst = 0;
    bit finished = 0;

    tx_irq_moderator #(.STEP_FAST(SF), .STEP_SLOW(SS)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .defer_en  (defer_en),
        .speed_100 (speed_100),
        .ref_tick  (ref_tick),
        .tx_start  (tx_start),
        .tx_done   (tx_done),
        .tx_ok     (tx_ok),
        .irq_done  (irq_done),
        .irq_defer (irq_defer)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: each high cycle of a pulse must match the head of its queue
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (irq_done) begin
                if (exp_done_q.size() == 0) chk(0, "R3/R12 unexpected irq_done", cyc, -1);
                else chk(exp_done_q.pop_front() == cyc, "R3 irq_done cycle", cyc, cyc);
            end
            if (irq_defer) begin
                if (exp_defer_q.size() == 0) chk(0, "R7/R10/R11 unexpected irq_defer", cyc, -1);
                else begin
                    int e;
                    e = exp_defer_q.pop_front();
                    chk(e == cyc, "R7/R8 irq_defer cycle", cyc, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Write with all reserved bits set, to show that they are ignored (R2)
    task automatic write_cfg(input int burst, input int tmo);
        cfg_wdata = {11'h7FF, 5'(burst), 4'hF, 12'(tmo)};
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_wdata = '0;
        m_burst = burst;
        m_cnt = 0;
    endtask

    // One completion; queues irq_done when the model reaches the limit
    task automatic complete(input bit ok, output int c);
        int lim;
        lim = (m_burst == 0) ? 1 : m_burst;
        tx_done = 1'b1;
        tx_ok = ok;
        c = cyc;
        if (ok) begin
            m_cnt++;
            if (m_cnt >= lim) begin
                exp_done_q.push_back(c + 1);
                m_cnt = 0;
            end
        end else m_cnt = 0;
        @(negedge clk);
        tx_done = 1'b0;
        tx_ok = 1'b0;
    endtask

    task automatic drain(input string req);
        chk(exp_done_q.size() == 0, {req, " pending irq_done"}, exp_done_q.size(), 0);
        chk(exp_defer_q.size() == 0, {req, " pending irq_defer"}, exp_defer_q.size(), 0);
    endtask

    initial begin
        int c;
        idle(3);
        // R1: outputs low while in reset
        chk(irq_done == 0 && irq_defer == 0, "R1 outputs in reset", irq_done + irq_defer, 0);
        rst_n = 1'b1;
        idle(2);
        chk(irq_done == 0 && irq_defer == 0, "R1 outputs after reset", irq_done + irq_defer, 0);

        // R1/R4: reset limit of zero acts as one
        m_burst = 0;
        complete(1, c); idle(3);
        drain("R1 R4 reset limit");

        // R2/R3/R6: limit 3, two rounds
        write_cfg(3, 0);
        repeat (6) begin complete(1, c); idle(2); end
        drain("R3 R6 limit three");

        // R5: failure resets the count
        complete(1, c); complete(1, c); complete(0, c); idle(1);
        complete(1, c); complete(1, c); idle(1);
        chk(exp_done_q.size() == 0 && m_cnt == 2, "R5 no early irq", exp_done_q.size(), 0);
        complete(1, c); idle(3);
        drain("R5 after failure");

        // R4/R12: limit zero, back-to-back completions give adjacent pulses
        write_cfg(0, 0);
        complete(1, c); complete(1, c); complete(1, c); idle(3);
        drain("R4 R12 back-to-back");

        // R2: maximum 5-bit limit of 31
        write_cfg(31, 0);
        repeat (31) complete(1, c);
        idle(3);
        drain("R2 limit 31");

        // R7/R8: fast step, timeout 5
        write_cfg(1, 5);
        defer_en = 1'b1;
        speed_100 = 1'b1;
        complete(1, c);
        exp_defer_q.push_back(c + 1 + 5 * SF);
        idle(5 * SF + 5);
        drain("R7 R8 fast");

        // R8: slow step, timeout 2
        write_cfg(1, 2);
        speed_100 = 1'b0;
        complete(1, c);
        exp_defer_q.push_back(c + 1 + 2 * SS);
        idle(2 * SS + 5);
        drain("R8 slow");
        speed_100 = 1'b1;

        // R10: transmit start cancels the countdown
        write_cfg(1, 5);
        complete(1, c);
        idle(8);
        tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
        idle(5 * SF + 10);
        drain("R10 cancel");

        // R10: start and completion in the same cycle, cancel wins
        tx_start = 1'b1;
        complete(1, c);
        tx_start = 1'b0;
        idle(5 * SF + 10);
        drain("R10 same cycle");

        // R9: freeze for 10 cycles mid-countdown
        complete(1, c);
        idle(6);
        defer_en = 1'b0;
        idle(10);
        defer_en = 1'b1;
        exp_defer_q.push_back(c + 1 + 5 * SF + 10);
        idle(5 * SF + 5);
        drain("R9 freeze");

        // R7: a second completion reloads the countdown
        complete(1, c);
        idle(10);
        complete(0, c);
        exp_defer_q.push_back(c + 1 + 5 * SF);
        idle(5 * SF + 5);
        drain("R7 reload");

        // R11: a zero timeout does not arm
        write_cfg(1, 0);
        complete(1, c);
        idle(40);
        drain("R11 zero timeout");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule